// File: doc/BRIEF.md
# Card Status Change Monitor

This block sits beside a removable 16-bit memory card socket and turns its slow, asynchronous status lines into clean status fields and sticky change events for the host. It watches two battery sense lines, two card sense lines, a ready/busy line and a write-protect line. Each line is brought into the clock domain through a two-stage synchronizer. The two battery lines are reduced to one of three health levels, and the two card sense lines are debounced into a single presence bit.

Four conditions raise sticky change flags: presence, battery level, ready and write protect. The host clears a flag by writing 1 to its bit. Each flag has an enable, and the OR of the enabled flags drives a registered interrupt line. While no card is seated, the live status reads as inactive and the battery, ready and write-protect flags are frozen. The host uses a small word-addressed port: address 0 is live status (read only), address 1 holds the flags, address 2 holds the enables, and address 3 reads zero.

Top module: `card_status_monitor`

## Requirements
- R1: The card counts as present (status bit 0 = 1) only after both card sense lines have been low and unchanged for DEB_CYCLES cycles. Any other stable pair of levels held that long makes it absent (bit 0 = 0).
- R2: A change on the card sense lines that reverts before DEB_CYCLES stable cycles leaves presence, and the presence flag, unchanged.
- R3: While present, status bits [2:1] give battery health: 2'b11 good when both battery lines are high, 2'b01 weak when line B is low and line A is high, and 2'b00 dead whenever line A is low, whatever line B is doing.
- R4: While present, status bit 3 is the synchronized ready level (1 = able to accept a command, 0 = busy), and status bit 4 is the synchronized write-protect level.
- R5: Flag register bits are bit 0 presence change, bit 1 battery level change, bit 2 ready change and bit 3 write-protect change. A flag sets when its condition changes and stays set until it is cleared.
- R6: Writing address 1 clears exactly the flag bits written as 1. Bits written as 0 keep their value.
- R7: A change that arrives in the same cycle as a clear of its flag leaves the flag set.
- R8: Address 2 holds enable bits [3:0] in the same bit order as the flags and reads back what was written. The interrupt output is the registered OR of every flag ANDed with its enable.
- R9: While the card is absent, status bits [4:1] read 0, and changes on the battery, ready or write-protect lines set no flag.
- R10: After reset, status, flags and enables read 0 and the interrupt output is 0.
- R11: The battery flag follows the decoded level, not the raw lines: a change on line B while line A is low sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| battSenseA | input | 1 | Battery sense line A, asynchronous |
| battSenseB | input | 1 | Battery sense line B, asynchronous |
| cardSenseA | input | 1 | Card sense line A, low when seated, asynchronous |
| cardSenseB | input | 1 | Card sense line B, low when seated, asynchronous |
| readyIn | input | 1 | Card ready (1) or busy (0), asynchronous |
| wrProtectIn | input | 1 | Card write-protect switch, asynchronous |
| regAddr | input | 2 | Host register address |
| regWr | input | 1 | Host write strobe for one cycle |
| regWrData | input | 4 | Host write data (clear mask or enables) |
| regRdData | output | 8 | Host read data for regAddr, combinational |
| irqOut | output | 1 | Registered interrupt request |

## Verification
The battery lines are driven through good, weak and dead. Dead is reached with line B both high and low, which separates a decoder that follows health levels from one that follows raw line edges. The card sense lines are driven through a full insertion, a glitch shorter than the debounce window, a single line going low, and a removal. These patterns separate the presence logic from plain synchronization and show that status is frozen and masked while no card is seated. A ready change is timed to land on the same edge as a host clear, which exposes the priority between setting and clearing a flag. Enable patterns show that a flag drives the interrupt only when its own enable is set.

// File: rtl/csm_pkg.sv
package csm_pkg;
  localparam int NUM_SRC = 4;
  localparam int SRC_DET  = 0;
  localparam int SRC_BATT = 1;
  localparam int SRC_RDY  = 2;
  localparam int SRC_WP   = 3;

  localparam logic [1:0] ADDR_STATUS = 2'd0;
  localparam logic [1:0] ADDR_FLAGS  = 2'd1;
  localparam logic [1:0] ADDR_ENABLE = 2'd2;

  typedef enum logic [1:0] {
    BATT_DEAD = 2'b00,
    BATT_WEAK = 2'b01,
    BATT_GOOD = 2'b11
  } battLevel_t;

  // Strobes from host control to the datapath
  typedef struct packed {
    logic [NUM_SRC-1:0] clrMask;
    logic               enLoad;
    logic [NUM_SRC-1:0] enData;
  } hostStrobe_t;

  function automatic battLevel_t battDecode(input logic lineA, input logic lineB);
    if (!lineA)      return BATT_DEAD;
    else if (!lineB) return BATT_WEAK;
    else             return BATT_GOOD;
  endfunction
endpackage

// File: rtl/csm_sync.sv
module csm_sync #(
  parameter int WIDTH = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic stageA, stageB;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        stageA <= RST_VAL[i];
        stageB <= RST_VAL[i];
      end else begin
        stageA <= dIn[i];
        stageB <= stageA;
      end
    end
    assign dOut[i] = stageB;
  end
endmodule

// File: rtl/csm_datapath.sv
module csm_datapath
  import csm_pkg::*;
#(
  parameter int DEB_CYCLES = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [5:0]         rawIn,   // {wp, ready, cardB, cardA, battB, battA}
  input  hostStrobe_t        strobe,
  output logic [4:0]         statusOut,
  output logic [NUM_SRC-1:0] flagsOut,
  output logic [NUM_SRC-1:0] enableOut,
  output logic               irqOut
);
  localparam int CNT_W = $clog2(DEB_CYCLES + 1);
  localparam logic [CNT_W-1:0] DEB_LIM = CNT_W'(DEB_CYCLES);
  localparam logic [5:0] SYNC_RST = 6'b01_1111;

  logic [5:0] syncV;
  csm_sync #(.WIDTH(6), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rstN(rstN), .dIn(rawIn), .dOut(syncV)
  );

  logic       battA, battB, rdyNow, wpNow;
  logic [1:0] cardPair;
  assign battA    = syncV[0];
  assign battB    = syncV[1];
  assign cardPair = syncV[3:2];
  assign rdyNow   = syncV[4];
  assign wpNow    = syncV[5];

  // Card presence debounce
  logic [1:0]       pairPrev;
  logic [CNT_W-1:0] stableCnt;
  logic             present, presentPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pairPrev    <= 2'b11;
      stableCnt   <= '0;
      present     <= 1'b0;
      presentPrev <= 1'b0;
    end else begin
      pairPrev    <= cardPair;
      presentPrev <= present;
      if (cardPair != pairPrev)  stableCnt <= '0;
      else if (stableCnt != DEB_LIM) stableCnt <= stableCnt + 1'b1;
      if (stableCnt == DEB_LIM) present <= (pairPrev == 2'b00);
    end
  end

  // Level tracking for change detection
  battLevel_t battNow, battPrev;
  logic       rdyPrev, wpPrev;
  assign battNow = battDecode(battA, battB);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      battPrev <= BATT_GOOD;
      rdyPrev  <= 1'b1;
      wpPrev   <= 1'b0;
    end else begin
      battPrev <= battNow;
      rdyPrev  <= rdyNow;
      wpPrev   <= wpNow;
    end
  end

  logic [NUM_SRC-1:0] setVec;
  always_comb begin
    setVec           = '0;
    setVec[SRC_DET]  = present != presentPrev;
    setVec[SRC_BATT] = present && (battNow != battPrev);
    setVec[SRC_RDY]  = present && (rdyNow != rdyPrev);
    setVec[SRC_WP]   = present && (wpNow != wpPrev);
  end

  // Sticky flags, enables and interrupt
  logic [NUM_SRC-1:0] flagsQ, enQ;
  logic               irqQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagsQ <= '0;
      enQ    <= '0;
      irqQ   <= 1'b0;
    end else begin
      flagsQ <= (flagsQ & ~strobe.clrMask) | setVec;
      if (strobe.enLoad) enQ <= strobe.enData;
      irqQ <= |(flagsQ & enQ);
    end
  end

  assign statusOut = present ? {wpNow, rdyNow, battNow, 1'b1} : 5'b0;
  assign flagsOut  = flagsQ;
  assign enableOut = enQ;
  assign irqOut    = irqQ;

  // R1: presence moves only once the sense pair has been stable long enough
  a_r1_debounced_presence: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(present) |-> $past(stableCnt) == DEB_LIM);

  // R5, R6: set flags not being cleared stay set
  a_r5_sticky_flags: assert property (@(posedge clk) disable iff (!rstN)
    (($past(flagsQ) & ~$past(strobe.clrMask)) & ~flagsQ) == '0);

  // R7: a change beats a clear in the same cycle
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    (setVec & strobe.clrMask) != '0 |=> ($past(setVec) & ~flagsQ) == '0);

  // R9: no battery or ready flag rises while the card is absent
  a_r9_absent_batt_frozen: assert property (@(posedge clk) disable iff (!rstN)
    !present |=> !(flagsQ[SRC_BATT] && !$past(flagsQ[SRC_BATT])));
  a_r9_absent_rdy_frozen: assert property (@(posedge clk) disable iff (!rstN)
    !present |=> !(flagsQ[SRC_RDY] && !$past(flagsQ[SRC_RDY])));
endmodule

// File: rtl/csm_ctrl.sv
module csm_ctrl
  import csm_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         regAddr,
  input  logic               regWr,
  input  logic [NUM_SRC-1:0] regWrData,
  input  logic [4:0]         statusIn,
  input  logic [NUM_SRC-1:0] flagsIn,
  input  logic [NUM_SRC-1:0] enableIn,
  output hostStrobe_t        strobe,
  output logic [7:0]         regRdData
);
  always_comb begin
    strobe.clrMask = (regWr && regAddr == ADDR_FLAGS) ? regWrData : '0;
    strobe.enLoad  = regWr && (regAddr == ADDR_ENABLE);
    strobe.enData  = regWrData;
  end

  always_comb begin
    case (regAddr)
      ADDR_STATUS: regRdData = {3'b0, statusIn};
      ADDR_FLAGS:  regRdData = {{(8-NUM_SRC){1'b0}}, flagsIn};
      ADDR_ENABLE: regRdData = {{(8-NUM_SRC){1'b0}}, enableIn};
      default:     regRdData = 8'h00;
    endcase
  end

  // R6: clears come only from a host write to the flag address
  a_r6_clear_needs_write: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrMask != '0 |-> regWr && regAddr == ADDR_FLAGS);
endmodule

// File: rtl/card_status_monitor.sv
module card_status_monitor
  import csm_pkg::*;
#(
  parameter int DEB_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       battSenseA,
  input  logic       battSenseB,
  input  logic       cardSenseA,
  input  logic       cardSenseB,
  input  logic       readyIn,
  input  logic       wrProtectIn,
  input  logic [1:0] regAddr,
  input  logic       regWr,
  input  logic [3:0] regWrData,
  output logic [7:0] regRdData,
  output logic       irqOut
);
  hostStrobe_t        strobe;
  logic [4:0]         status;
  logic [NUM_SRC-1:0] flags, enables;

  csm_datapath #(.DEB_CYCLES(DEB_CYCLES)) u_dp (
    .clk(clk), .rstN(rstN),
    .rawIn({wrProtectIn, readyIn, cardSenseB, cardSenseA, battSenseB, battSenseA}),
    .strobe(strobe), .statusOut(status), .flagsOut(flags),
    .enableOut(enables), .irqOut(irqOut)
  );

  csm_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr),
    .regWrData(regWrData), .statusIn(status), .flagsIn(flags),
    .enableIn(enables), .strobe(strobe), .regRdData(regRdData)
  );
endmodule

// File: tb/card_status_monitor_tb_top.sv
module card_status_monitor_tb_top;
  localparam int DEB = 4;

  logic clk = 1'b0, rstN = 1'b0;
  logic battSenseA = 1, battSenseB = 1, cardSenseA = 1, cardSenseB = 1;
  logic readyIn = 1, wrProtectIn = 0;
  logic [1:0] regAddr = 0;
  logic regWr = 0;
  logic [3:0] regWrData = 0;
  logic [7:0] regRdData;
  logic irqOut;

  int vecCnt = 0, missCnt = 0;
  bit done = 0;

  always #5 clk = ~clk;

  card_status_monitor #(.DEB_CYCLES(DEB)) dut_i (
    .clk(clk), .rstN(rstN), .battSenseA(battSenseA), .battSenseB(battSenseB),
    .cardSenseA(cardSenseA), .cardSenseB(cardSenseB), .readyIn(readyIn),
    .wrProtectIn(wrProtectIn), .regAddr(regAddr), .regWr(regWr),
    .regWrData(regWrData), .regRdData(regRdData), .irqOut(irqOut)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    vecCnt++;
    if (got !== exp) begin
      missCnt++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  task automatic readReg(input logic [1:0] a, output logic [7:0] v);
    regAddr = a;
    #1 v = regRdData;
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [3:0] d);
    regAddr = a; regWrData = d; regWr = 1;
    @(negedge clk);
    regWr = 0;
  endtask

  task automatic expectReg(input string req, input logic [1:0] a, input logic [7:0] exp);
    logic [7:0] v;
    readReg(a, v);
    check(req, v, exp);
  endtask

  task automatic testReset();
    expectReg("R10 status", 2'd0, 8'h00);
    expectReg("R10 flags", 2'd1, 8'h00);
    expectReg("R10 enables", 2'd2, 8'h00);
    check("R10 irq", {7'b0, irqOut}, 8'h00);
  endtask

  task automatic testInsert();
    cardSenseA = 0; cardSenseB = 0;
    tick(DEB + 8);
    expectReg("R1 present good ready", 2'd0, 8'h0F);
    expectReg("R5 presence flag", 2'd1, 8'h01);
    check("R8 irq masked", {7'b0, irqOut}, 8'h00);
    writeReg(2'd1, 4'h1);
    expectReg("R6 clear presence", 2'd1, 8'h00);
  endtask

  task automatic testBattery();
    battSenseB = 0; tick(5);
    expectReg("R3 weak", 2'd0, 8'h0B);
    expectReg("R5 batt flag", 2'd1, 8'h02);
    writeReg(2'd1, 4'h2);
    battSenseA = 0; battSenseB = 1; tick(5);
    expectReg("R3 dead B high", 2'd0, 8'h09);
    expectReg("R5 batt flag dead", 2'd1, 8'h02);
    writeReg(2'd1, 4'h2);
    battSenseB = 0; tick(5);
    expectReg("R3 dead B low", 2'd0, 8'h09);
    expectReg("R11 no flag on B while dead", 2'd1, 8'h00);
    battSenseA = 1; battSenseB = 1; tick(5);
    expectReg("R3 good again", 2'd0, 8'h0F);
  endtask

  task automatic testIrq();
    writeReg(2'd2, 4'h2);
    expectReg("R8 enable readback", 2'd2, 8'h02);
    tick(2);
    check("R8 irq from batt flag", {7'b0, irqOut}, 8'h01);
    writeReg(2'd1, 4'hD);
    expectReg("R6 zero-bit keeps batt flag", 2'd1, 8'h02);
    writeReg(2'd1, 4'h2); tick(2);
    check("R8 irq drops after clear", {7'b0, irqOut}, 8'h00);
    readyIn = 0; tick(5);
    expectReg("R4 busy", 2'd0, 8'h07);
    expectReg("R5 ready flag", 2'd1, 8'h04);
    check("R8 ready flag not enabled", {7'b0, irqOut}, 8'h00);
    writeReg(2'd2, 4'h4); tick(2);
    check("R8 irq ready enabled", {7'b0, irqOut}, 8'h01);
  endtask

  task automatic testSetWins();
    logic [7:0] v;
    readyIn = 1;           // ready flag already set
    @(negedge clk);
    @(negedge clk);
    regAddr = 2'd1; regWrData = 4'h4; regWr = 1;
    @(negedge clk);
    regWr = 0;
    readReg(2'd1, v);
    check("R7 set beats clear", v & 8'h04, 8'h04);
    writeReg(2'd1, 4'h4);
    expectReg("R6 plain clear", 2'd1, 8'h00);
    writeReg(2'd2, 4'h0);
  endtask

  task automatic testWp();
    wrProtectIn = 1; tick(5);
    expectReg("R4 write protect", 2'd0, 8'h1F);
    expectReg("R5 wp flag", 2'd1, 8'h08);
    writeReg(2'd1, 4'h8);
    wrProtectIn = 0; tick(5);
    writeReg(2'd1, 4'h8);
  endtask

  task automatic testGlitch();
    cardSenseA = 1; cardSenseB = 1;
    tick(DEB - 2);
    cardSenseA = 0; cardSenseB = 0;
    tick(DEB + 8);
    expectReg("R2 glitch keeps presence", 2'd0, 8'h0F);
    expectReg("R2 glitch no flag", 2'd1, 8'h00);
  endtask

  task automatic testRemoval();
    cardSenseA = 1; cardSenseB = 1;
    tick(DEB + 8);
    expectReg("R9 absent status inactive", 2'd0, 8'h00);
    expectReg("R5 removal flag", 2'd1, 8'h01);
    writeReg(2'd1, 4'h1);
    battSenseA = 0; readyIn = 0; wrProtectIn = 1; tick(5);
    expectReg("R9 no flags while absent", 2'd1, 8'h00);
    battSenseA = 1; readyIn = 1; wrProtectIn = 0; tick(5);
    cardSenseA = 0; tick(DEB + 8);
    expectReg("R1 single line low absent", 2'd0, 8'h00);
    cardSenseB = 0; tick(DEB + 8);
    expectReg("R1 reinsert present", 2'd0, 8'h0F);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    testReset();
    testInsert();
    testBattery();
    testIrq();
    testSetWins();
    testWp();
    testGlitch();
    testRemoval();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, missCnt);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      missCnt++;
      $display("FAIL watchdog R10: got hung run expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, missCnt);
      $finish;
    end
  end
endmodule